// File: doc/BRIEF.md
# Ring Rotator with Condition Bit

This block rotates a 32-bit operand together with a single condition flag. The operand and the flag form one 33-bit ring: the flag sits above bit 31, and bits pass through it as the ring turns. A signed count picks both the direction and the distance. A positive count turns the ring toward the more significant end, and a negative count turns it the other way.

The flag lives in a register inside the block. Each rotate reads the stored flag as its input bit and writes the bit that leaves the operand back into that register. A chain of rotates therefore carries the flag from one operation to the next, as a sequence of rotate operations on a processor datapath would. A load input lets the caller force the flag to a chosen value. A forced value can either replace the stored flag for the rotate in the same cycle, or be written on its own while no rotate is issued. All results appear one cycle after the strobe.

Top module: `ring33_rotator`

## Requirements
- R1: While `rst_n` is low, `result_o` is 0x00000000, and `cond_o` and `done_o` are 0.
- R2: The ring is `{flag, operand}`, with the flag as bit 32. A count of +1 moves the input flag into result bit 0 and operand bit 31 into `cond_o`. For example, 0x80000001 with flag 0 gives 0x00000002 with flag 1.
- R3: A count of -1 moves the input flag into result bit 31 and operand bit 0 into `cond_o`. For example, 0x80000001 with flag 0 gives 0x40000000 with flag 1.
- R4: `count_i` is a 6-bit two's-complement value, and the legal range is -31 to +31. A count n turns the ring left by n modulo 33. For example, 0x80000001 by +31 gives 0xA0000000 or 0xE0000000, and by -31 gives 0x00000005 or 0x00000007, for input flag 0 or 1. In all four cases `cond_o` ends at 0. The same operand by +7 with flag 1 gives 0x000000E0 with flag 0.
- R5: A count of 0 returns the operand unchanged and leaves the flag unchanged.
- R6: `done_o` is high in exactly the cycle after a cycle with `valid_i` high. `result_o` and `cond_o` update on that same edge.
- R7: A rotate issued with `cond_ld_i` low uses the flag left by the previous operation as its input bit.
- R8: When `cond_ld_i` is high together with `valid_i`, the rotate uses `cond_val_i` as its input bit. When `cond_ld_i` is high without `valid_i`, `cond_o` takes `cond_val_i` and `result_o` keeps its value.
- R9: When neither `valid_i` nor `cond_ld_i` is high, `result_o` and `cond_o` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | Start a rotate this cycle |
| cond_ld_i | input | 1 | Force the flag to `cond_val_i` |
| cond_val_i | input | 1 | Value used when forcing the flag |
| operand_i | input | 32 | Value to rotate |
| count_i | input | 6 | Signed rotate count: positive turns left, negative turns right |
| result_o | output | 32 | Rotated value, registered |
| cond_o | output | 1 | Stored condition flag |
| done_o | output | 1 | Result is valid this cycle |

## Verification
The assertions assume that `count_i` never carries -32 in a cycle with `valid_i` high. The block still produces a defined result for that code (a left turn by 1), but the checks treat it as outside the contract. The stimulus keeps every count inside -31 to +31. The directed vectors cover the sign boundaries and zero. A sweep walks every legal count against a single-step ring model. The flag-chaining and forced-flag cases are driven as separate directed sequences.

// File: rtl/ring33_rotator.sv
module ring33_rotator #(
  parameter int W = 32,
  parameter int CW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          valid_i,
  input  logic          cond_ld_i,
  input  logic          cond_val_i,
  input  logic [W-1:0]  operand_i,
  input  logic [CW-1:0] count_i,
  output logic [W-1:0]  result_o,
  output logic          cond_o,
  output logic          done_o
);
  localparam int RW = W + 1;
  localparam logic [CW-1:0] RING_LEN = CW'(RW);
  localparam logic [CW-1:0] NEG_LIMIT = {1'b1, {(CW-1){1'b0}}};

  logic            flag_in;
  logic [RW-1:0]   ring;
  logic [CW-1:0]   left_amt;
  logic [2*RW-1:0] dbl;
  logic [RW-1:0]   turned;

  assign flag_in  = cond_ld_i ? cond_val_i : cond_o;
  assign ring     = {flag_in, operand_i};
  assign left_amt = count_i[CW-1] ? count_i + RING_LEN : count_i;
  assign dbl      = {ring, ring} << left_amt;
  assign turned   = dbl[2*RW-1:RW];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result_o <= '0;
      cond_o   <= 1'b0;
      done_o   <= 1'b0;
    end else begin
      done_o <= valid_i;
      if (valid_i) begin
        result_o <= turned[W-1:0];
        cond_o   <= turned[W];
      end else if (cond_ld_i) begin
        cond_o <= cond_val_i;
      end
    end
  end

  p_count_legal_r4: assert property (@(posedge clk) disable iff (!rst_n)
    valid_i |-> count_i != NEG_LIMIT);

  p_left_one_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && count_i == CW'(1)) |=>
      (result_o == {$past(operand_i[W-2:0]), $past(flag_in)}) && (cond_o == $past(operand_i[W-1])));

  p_right_one_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && count_i == {CW{1'b1}}) |=>
      (result_o == {$past(flag_in), $past(operand_i[W-1:1])}) && (cond_o == $past(operand_i[0])));

  p_zero_count_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && count_i == '0) |=> (result_o == $past(operand_i)) && (cond_o == $past(flag_in)));

  p_done_follows_r6: assert property (@(posedge clk) disable iff (!rst_n)
    valid_i |=> done_o);

  p_done_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_i |=> !done_o);

  p_force_only_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!valid_i && cond_ld_i) |=> (cond_o == $past(cond_val_i)) && $stable(result_o));

  p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!valid_i && !cond_ld_i) |=> $stable(result_o) && $stable(cond_o));
endmodule

// File: tb/ring33_rotator_tb.sv
module ring33_rotator_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid_i = 1'b0;
  logic        cond_ld_i = 1'b0;
  logic        cond_val_i = 1'b0;
  logic [31:0] operand_i = '0;
  logic [5:0]  count_i = '0;
  logic [31:0] result_o;
  logic        cond_o;
  logic        done_o;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  ring33_rotator u_dut (
    .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .cond_ld_i(cond_ld_i),
    .cond_val_i(cond_val_i), .operand_i(operand_i), .count_i(count_i),
    .result_o(result_o), .cond_o(cond_o), .done_o(done_o)
  );

  // {flag in, count, operand, expected result, expected flag}
  localparam int NV = 9;
  localparam logic [71:0] VEC [NV] = '{
    {1'b0, 6'sd1,   32'h80000001, 32'h00000002, 1'b1},
    {1'b0, -6'sd1,  32'h80000001, 32'h40000000, 1'b1},
    {1'b0, 6'sd31,  32'h80000001, 32'hA0000000, 1'b0},
    {1'b1, 6'sd31,  32'h80000001, 32'hE0000000, 1'b0},
    {1'b0, -6'sd31, 32'h80000001, 32'h00000005, 1'b0},
    {1'b1, -6'sd31, 32'h80000001, 32'h00000007, 1'b0},
    {1'b1, 6'sd7,   32'h80000001, 32'h000000E0, 1'b0},
    {1'b1, 6'sd0,   32'h80000001, 32'h80000001, 1'b1},
    {1'b0, 6'sd0,   32'h00000000, 32'h00000000, 1'b0}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic issue(input logic v, input logic ld, input logic lv,
                       input logic [5:0] cnt, input logic [31:0] op);
    @(negedge clk);
    valid_i = v; cond_ld_i = ld; cond_val_i = lv; count_i = cnt; operand_i = op;
    @(posedge clk);
    #1;
    @(negedge clk);
    valid_i = 1'b0; cond_ld_i = 1'b0;
  endtask

  function automatic logic [32:0] model(input logic c, input logic [31:0] op, input int n);
    logic [31:0] v = op;
    logic f = c;
    logic t;
    if (n > 0) begin
      for (int i = 0; i < n; i++) begin t = v[31]; v = {v[30:0], f}; f = t; end
    end else begin
      for (int i = 0; i < -n; i++) begin t = v[0]; v = {f, v[31:1]}; f = t; end
    end
    return {f, v};
  endfunction

  initial begin
    #(4 * 200000);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [71:0] e;
    logic [32:0] m;
    repeat (3) @(posedge clk);
    #1;
    check("R1 result", result_o, 32'h0);
    check("R1 cond", {31'b0, cond_o}, 32'h0);
    check("R1 done", {31'b0, done_o}, 32'h0);
    @(negedge clk); rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      e = VEC[i];
      issue(1'b1, 1'b1, e[71], e[70:65], e[64:33]);
      check($sformatf("R2/R3/R4/R5 vec%0d result", i), result_o, e[32:1]);
      check($sformatf("R2/R3/R4/R5 vec%0d cond", i), {31'b0, cond_o}, {31'b0, e[0]});
    end

    for (int n = -31; n <= 31; n++) begin
      m = model(n[0], 32'hC3A50F96, n);
      issue(1'b1, 1'b1, n[0], 6'(n), 32'hC3A50F96);
      check($sformatf("R4 sweep %0d result", n), result_o, m[31:0]);
      check($sformatf("R4 sweep %0d cond", n), {31'b0, cond_o}, {31'b0, m[32]});
    end

    // R8: force flag without rotate, result kept
    issue(1'b1, 1'b1, 1'b0, 6'd0, 32'h5A5A1234);
    issue(1'b0, 1'b1, 1'b1, 6'd3, 32'hFFFFFFFF);
    check("R8 forced cond", {31'b0, cond_o}, 32'h1);
    check("R8 result kept", result_o, 32'h5A5A1234);
    check("R6 done low after no strobe", {31'b0, done_o}, 32'h0);

    // R7: chained flag
    issue(1'b1, 1'b1, 1'b0, 6'd1, 32'h80000001);
    check("R6 done after strobe", {31'b0, done_o}, 32'h1);
    issue(1'b1, 1'b0, 1'b0, 6'd1, 32'h00000000);
    check("R7 chained result", result_o, 32'h00000001);
    check("R7 chained cond", {31'b0, cond_o}, 32'h0);
    issue(1'b1, 1'b0, 1'b0, -6'sd1, 32'h00000001);
    check("R7 chained right result", result_o, 32'h00000000);
    check("R7 chained right cond", {31'b0, cond_o}, 32'h1);

    // R9: idle with changing inputs
    issue(1'b0, 1'b0, 1'b0, 6'd5, 32'hDEADBEEF);
    issue(1'b0, 1'b0, 1'b1, -6'sd9, 32'h12345678);
    check("R9 hold result", result_o, 32'h00000000);
    check("R9 hold cond", {31'b0, cond_o}, 32'h1);

    // R1 mid-run reset
    @(negedge clk); rst_n = 1'b0;
    #1;
    check("R1 reset cond", {31'b0, cond_o}, 32'h0);
    @(negedge clk); rst_n = 1'b1;

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule